// File: doc/BRIEF.md
# Thermostat alarm output controller

This block watches a stream of signed temperature results from a conversion engine and drives a single over-temperature alarm pin. Each result arrives with a one-cycle strobe. The block zeroes the bits that lie below the selected resolution, publishes the masked value, and compares it against a high trip setpoint and a lower release setpoint. The release setpoint gives the thermostat its hysteresis.

There are two operating modes. In comparator mode the pin behaves as a thermostat. It turns on after enough consecutive hot readings and turns off on the first reading below the release setpoint. In interrupt mode the pin signals a latched event. The event stays set until a register read or a shutdown clears it. After each event the block switches to watching the opposite condition, so hot and cold events alternate.

Configuration is captured from a set of input fields on a load strobe. Out of reset the block already runs as a standalone thermostat with fixed setpoints, so it needs no configuration to be useful.

Top module: `thermo_alarm`

## Requirements
- R1: After reset the block is in comparator mode. The high setpoint is 80 C (5000h), the release setpoint is 75 C (4B00h), resolution is 9 bits, one violation is needed, the pin is active-low and inactive (reads 1), and `temp_o` is 0000h.
- R2: `temp_o` takes the accepted conversion word at the clock edge of its strobe, with the bits below the resolution forced to zero. `cfg_res_i` 0, 1, 2 and 3 select 9, 10, 11 and 12 kept bits, counted from the MSb of the 16-bit two's complement word.
- R3: In comparator mode the alarm turns on once the masked temperature is at or above the high setpoint (signed compare) for the programmed number of consecutive conversions.
- R4: In comparator mode an active alarm stays on until the first conversion whose masked value is strictly below the release setpoint. A value equal to the release setpoint does not release it.
- R5: `cfg_cnt_i` 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive violating conversions. Any accepted conversion that does not violate restarts the count from zero.
- R6: In interrupt mode (`cfg_mode_i`=1) an event sets the alarm after the programmed number of consecutive conversions at or above the high setpoint. The alarm then holds, whatever the later conversions are, until `reg_read_i` or `shutdown_i` clears it.
- R7: In interrupt mode each event flips the watched condition. After a high event only conversions strictly below the release setpoint can raise the next event, and after a low event only conversions at or above the high setpoint can. Repeated violations of the same kind give a single event, even when clears come between them.
- R8: If a register read and a conversion that completes an event fall in the same cycle, the read clears only the alarm that was already standing and the new event is set. While an event is standing, conversions neither count nor raise events.
- R9: `shutdown_i` ignores conversions (`temp_o` holds), clears an interrupt-mode alarm, restarts the count and makes interrupt mode watch the high setpoint again.
- R10: `cfg_pol_i`=1 makes the pin active-high and 0 makes it active-low.
- R11: A configuration load takes effect at the clock edge of `cfg_load_i` and restarts the count. A load that changes the mode also clears the alarm and returns interrupt mode to watching the high setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_valid_i | input | 1 | Conversion result strobe |
| conv_temp_i | input | 16 | Conversion result, two's complement, left-justified |
| cfg_load_i | input | 1 | Capture all configuration fields |
| cfg_hi_i | input | 16 | High trip setpoint |
| cfg_lo_i | input | 16 | Release (hysteresis) setpoint |
| cfg_res_i | input | 2 | Resolution select |
| cfg_cnt_i | input | 2 | Consecutive violation count select |
| cfg_mode_i | input | 1 | 0 comparator, 1 interrupt |
| cfg_pol_i | input | 1 | Pin polarity, 1 active-high |
| reg_read_i | input | 1 | A register was read; clears an interrupt event |
| shutdown_i | input | 1 | Shutdown request |
| alarm_o | output | 1 | Alarm pin level |
| temp_o | output | 16 | Last accepted masked temperature |

## Verification
The interesting collision is a register read landing in the same cycle as a conversion, in interrupt mode. The bench provokes it twice. In the first case an event is already standing, so the read must clear it while the conversion is neither counted nor allowed to fire. In the second case no event is standing and the conversion completes a low event, which must survive the read. A scoreboard fed by the stimulus tasks holds the expected masked value and pin level for each accepted conversion. The pin is also checked directly after reads, shutdowns and configuration loads.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int TW        = 16;
  localparam int RES_W     = 2;
  localparam int CSEL_W    = 2;
  localparam int CNT_W     = 3;
  localparam int MIN_KEEP  = 9;
  localparam int BASE_DROP = TW - MIN_KEEP;

  typedef enum logic {MODE_CMP = 1'b0, MODE_INT = 1'b1} mode_e;
  typedef enum logic {WATCH_HI = 1'b0, WATCH_LO = 1'b1} watch_e;

  typedef struct packed {
    logic [TW-1:0]     hi;
    logic [TW-1:0]     lo;
    logic [RES_W-1:0]  res;
    logic [CSEL_W-1:0] csel;
    mode_e             mode;
    logic              pol;
  } cfg_t;

  // ones in the kept (upper) bit positions
  function automatic logic [TW-1:0] keep_mask(logic [RES_W-1:0] res);
    int drop;
    drop = BASE_DROP - int'(res);
    return {TW{1'b1}} << drop;
  endfunction

  function automatic logic [CNT_W-1:0] fault_limit(logic [CSEL_W-1:0] sel);
    logic [CNT_W-1:0] lim;
    case (sel)
      2'd0:    lim = CNT_W'(1);
      2'd1:    lim = CNT_W'(2);
      2'd2:    lim = CNT_W'(4);
      default: lim = CNT_W'(6);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/thermo_rst_sync.sv
module thermo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/thermo_cfg.sv
module thermo_cfg
  import thermo_pkg::*;
#(
  parameter logic [TW-1:0] HI_RESET = 16'h5000,
  parameter logic [TW-1:0] LO_RESET = 16'h4B00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TW-1:0]     hi_i,
  input  logic [TW-1:0]     lo_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [CSEL_W-1:0] csel_i,
  input  logic              mode_i,
  input  logic              pol_i,
  output cfg_t              cfg_o,
  output logic              mode_chg_o
);
  cfg_t cfg_q, cfg_d;
  cfg_t cfg_new;

  always_comb begin
    cfg_new.hi   = hi_i;
    cfg_new.lo   = lo_i;
    cfg_new.res  = res_i;
    cfg_new.csel = csel_i;
    cfg_new.mode = mode_e'(mode_i);
    cfg_new.pol  = pol_i;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = cfg_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.hi   <= HI_RESET;
      cfg_q.lo   <= LO_RESET;
      cfg_q.res  <= '0;
      cfg_q.csel <= '0;
      cfg_q.mode <= MODE_CMP;
      cfg_q.pol  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign mode_chg_o = load_i && (cfg_new.mode != cfg_q.mode);
endmodule

// File: rtl/thermo_mask.sv
module thermo_mask
  import thermo_pkg::*;
(
  input  logic [TW-1:0]    temp_i,
  input  logic [RES_W-1:0] res_i,
  output logic [TW-1:0]    temp_o
);
  logic [TW-1:0] keep;

  assign keep = keep_mask(res_i);

  for (genvar b = 0; b < TW; b++) begin : g_bit
    if (b >= BASE_DROP) begin : g_fixed
      assign temp_o[b] = temp_i[b];
    end else begin : g_sel
      assign temp_o[b] = temp_i[b] & keep[b];
    end
  end
endmodule

// File: rtl/thermo_fault.sv
module thermo_fault
  import thermo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              hit_i,
  input  logic              restart_i,
  input  logic [CSEL_W-1:0] csel_i,
  output logic              fire_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             reach;

  assign limit   = fault_limit(csel_i);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign reach   = (cnt_inc >= limit);
  assign fire_o  = step_i && hit_i && !restart_i && reach;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)                 cnt_d = '0;
    else if (step_i && !hit_i)     cnt_d = '0;
    else if (step_i && reach)      cnt_d = '0;
    else if (step_i)               cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
  import thermo_pkg::*;
#(
  parameter logic [15:0] HI_RESET = 16'h5000,
  parameter logic [15:0] LO_RESET = 16'h4B00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        conv_valid_i,
  input  logic [15:0] conv_temp_i,
  input  logic        cfg_load_i,
  input  logic [15:0] cfg_hi_i,
  input  logic [15:0] cfg_lo_i,
  input  logic [1:0]  cfg_res_i,
  input  logic [1:0]  cfg_cnt_i,
  input  logic        cfg_mode_i,
  input  logic        cfg_pol_i,
  input  logic        reg_read_i,
  input  logic        shutdown_i,
  output logic        alarm_o,
  output logic [15:0] temp_o
);
  logic             rst_n;
  cfg_t             cfg;
  logic             mode_chg;
  logic [TW-1:0]    masked;
  logic             conv_ok;
  logic             step;
  logic             hit;
  logic             restart;
  logic             fire;
  logic [CNT_W-1:0] fault_cnt;
  logic             int_mode;

  logic             alarm_q, alarm_d;
  watch_e           watch_q, watch_d;
  logic [TW-1:0]    temp_q;
  logic             temp_en;

  thermo_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  thermo_cfg #(.HI_RESET(HI_RESET), .LO_RESET(LO_RESET)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (cfg_load_i),
    .hi_i      (cfg_hi_i),
    .lo_i      (cfg_lo_i),
    .res_i     (cfg_res_i),
    .csel_i    (cfg_cnt_i),
    .mode_i    (cfg_mode_i),
    .pol_i     (cfg_pol_i),
    .cfg_o     (cfg),
    .mode_chg_o(mode_chg)
  );

  thermo_mask u_mask (
    .temp_i(conv_temp_i),
    .res_i (cfg.res),
    .temp_o(masked)
  );

  assign int_mode = (cfg.mode == MODE_INT);
  assign conv_ok  = conv_valid_i && !shutdown_i;
  assign step     = conv_ok && !alarm_q;
  assign restart  = shutdown_i || cfg_load_i;

  always_comb begin
    if (int_mode && watch_q == WATCH_LO) hit = ($signed(masked) < $signed(cfg.lo));
    else                                 hit = ($signed(masked) >= $signed(cfg.hi));
  end

  thermo_fault u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .step_i   (step),
    .hit_i    (hit),
    .restart_i(restart),
    .csel_i   (cfg.csel),
    .fire_o   (fire),
    .cnt_o    (fault_cnt)
  );

  // alarm / watch next state
  always_comb begin
    alarm_d = alarm_q;
    watch_d = watch_q;
    if (mode_chg) begin
      alarm_d = 1'b0;
      watch_d = WATCH_HI;
    end else if (int_mode) begin
      if (fire) begin
        alarm_d = 1'b1;
        watch_d = (watch_q == WATCH_HI) ? WATCH_LO : WATCH_HI;
      end else if (reg_read_i || shutdown_i) begin
        alarm_d = 1'b0;
      end
      if (shutdown_i) watch_d = WATCH_HI;
    end else begin
      if (fire)
        alarm_d = 1'b1;
      else if (alarm_q && conv_ok && ($signed(masked) < $signed(cfg.lo)))
        alarm_d = 1'b0;
      watch_d = WATCH_HI;
    end
  end

  assign temp_en = conv_ok;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      watch_q <= WATCH_HI;
    end else begin
      alarm_q <= alarm_d;
      watch_q <= watch_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (temp_en) temp_q <= masked;
  end

  assign alarm_o = cfg.pol ? alarm_q : !alarm_q;
  assign temp_o  = temp_q;
endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        conv_valid_i,
  input logic        shutdown_i,
  input logic        reg_read_i,
  input logic        cfg_load_i,
  input logic [15:0] temp_o,
  input logic        mode_bit,
  input logic [1:0]  res_bits,
  input logic [1:0]  csel_bits,
  input logic        alarm_q,
  input logic [2:0]  fault_cnt
);
  logic [2:0]  lim;
  logic [15:0] tail;

  always_comb begin
    case (csel_bits)
      2'd0:    lim = 3'd1;
      2'd1:    lim = 3'd2;
      2'd2:    lim = 3'd4;
      default: lim = 3'd6;
    endcase
  end

  assign tail = temp_o << (9 + int'(res_bits));

  AST_RES_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (conv_valid_i && !shutdown_i && !cfg_load_i) |=> (tail == 16'h0000)); // R2

  AST_TEMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!conv_valid_i || shutdown_i) |=> $stable(temp_o)); // R9

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_bit && reg_read_i && !conv_valid_i && !cfg_load_i) |=> !alarm_q); // R6

  AST_SHDN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_bit && shutdown_i && !cfg_load_i) |=> !alarm_q); // R9

  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_bit && alarm_q && !conv_valid_i && !cfg_load_i) |=> alarm_q); // R4

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    fault_cnt < lim); // R5
endmodule

bind thermo_alarm thermo_alarm_chk u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .conv_valid_i(conv_valid_i),
  .shutdown_i  (shutdown_i),
  .reg_read_i  (reg_read_i),
  .cfg_load_i  (cfg_load_i),
  .temp_o      (temp_o),
  .mode_bit    (int_mode),
  .res_bits    (cfg.res),
  .csel_bits   (cfg.csel),
  .alarm_q     (alarm_q),
  .fault_cnt   (fault_cnt)
);

// File: tb/test_thermo_alarm.sv
module test_thermo_alarm;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        conv_valid_i = 1'b0;
  logic [15:0] conv_temp_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [15:0] cfg_hi_i = '0;
  logic [15:0] cfg_lo_i = '0;
  logic [1:0]  cfg_res_i = '0;
  logic [1:0]  cfg_cnt_i = '0;
  logic        cfg_mode_i = 1'b0;
  logic        cfg_pol_i = 1'b0;
  logic        reg_read_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic        alarm_o;
  logic [15:0] temp_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] t;
    logic        pin;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  thermo_alarm i_thermo_alarm (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .conv_valid_i(conv_valid_i),
    .conv_temp_i (conv_temp_i),
    .cfg_load_i  (cfg_load_i),
    .cfg_hi_i    (cfg_hi_i),
    .cfg_lo_i    (cfg_lo_i),
    .cfg_res_i   (cfg_res_i),
    .cfg_cnt_i   (cfg_cnt_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_pol_i   (cfg_pol_i),
    .reg_read_i  (reg_read_i),
    .shutdown_i  (shutdown_i),
    .alarm_o     (alarm_o),
    .temp_o      (temp_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(bit cv, logic [15:0] t, bit rd, bit sd);
    @(negedge clk);
    conv_valid_i = cv; conv_temp_i = t; reg_read_i = rd; shutdown_i = sd;
    @(negedge clk);
    conv_valid_i = 1'b0; reg_read_i = 1'b0; shutdown_i = 1'b0;
  endtask

  task automatic conv(logic [15:0] t, logic [15:0] et, logic pin, string tag);
    exp_t e;
    e.t = et; e.pin = pin; e.tag = tag;
    sb.push_back(e);
    drive(1'b1, t, 1'b0, 1'b0);
  endtask

  task automatic conv_read(logic [15:0] t, logic [15:0] et, logic pin, string tag);
    exp_t e;
    e.t = et; e.pin = pin; e.tag = tag;
    sb.push_back(e);
    drive(1'b1, t, 1'b1, 1'b0);
  endtask

  task automatic load(logic [15:0] hi, logic [15:0] lo, logic [1:0] res,
                      logic [1:0] cnt, bit mode, bit pol);
    @(negedge clk);
    cfg_hi_i = hi; cfg_lo_i = lo; cfg_res_i = res; cfg_cnt_i = cnt;
    cfg_mode_i = mode; cfg_pol_i = pol; cfg_load_i = 1'b1;
    @(negedge clk);
    cfg_load_i = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (conv_valid_i && !shutdown_i) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: unexpected conversion, actual %h expected none", temp_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " temp"}, temp_o, e.t);
          chk({e.tag, " pin"}, {15'b0, alarm_o}, {15'b0, e.pin});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pin", {15'b0, alarm_o}, 16'h0001);
    chk("R1 reset temp", temp_o, 16'h0000);

    // defaults: comparator, 80/75 C, 9 bits, count 1, active-low
    conv(16'h1910, 16'h1900, 1'b1, "R2 9-bit mask");
    conv(16'h5000, 16'h5000, 1'b0, "R1 R3 default trip");
    conv(16'h4C00, 16'h4C00, 1'b0, "R4 above release");
    conv(16'h4B00, 16'h4B00, 1'b0, "R4 equal release");
    conv(16'h4AF0, 16'h4A80, 1'b1, "R4 below release");

    // comparator, 12 bits, count 2, active-high, +0.5 / -0.5
    load(16'h0080, 16'hFF80, 2'd3, 2'd1, 1'b0, 1'b1);
    chk("R10 active-high idle", {15'b0, alarm_o}, 16'h0000);
    conv(16'hE6F0, 16'hE6F0, 1'b0, "R2 12-bit");
    conv(16'h0080, 16'h0080, 1'b0, "R5 first of two");
    conv(16'h0000, 16'h0000, 1'b0, "R5 restart");
    conv(16'h0080, 16'h0080, 1'b0, "R5 first again");
    conv(16'h7D00, 16'h7D00, 1'b1, "R3 second hit");
    conv(16'hFF80, 16'hFF80, 1'b1, "R4 equal low");
    conv(16'hC900, 16'hC900, 1'b0, "R4 release");
    load(16'h0080, 16'hFF80, 2'd1, 2'd1, 1'b0, 1'b1);
    conv(16'hE6F0, 16'hE6C0, 1'b0, "R2 10-bit");
    load(16'h0080, 16'hFF80, 2'd2, 2'd1, 1'b0, 1'b1);
    conv(16'hE6F0, 16'hE6E0, 1'b0, "R2 11-bit");

    // interrupt mode, count 1, active-high, hi 25 C, lo 0 C
    load(16'h1900, 16'h0000, 2'd3, 2'd0, 1'b1, 1'b1);
    conv(16'h1910, 16'h1910, 1'b1, "R6 high event");
    conv(16'h1910, 16'h1910, 1'b1, "R6 event held");
    drive(1'b0, 16'h0000, 1'b1, 1'b0);
    chk("R6 read clears", {15'b0, alarm_o}, 16'h0000);
    conv(16'h1910, 16'h1910, 1'b0, "R7 high again ignored");
    conv(16'hFF80, 16'hFF80, 1'b1, "R7 low event");
    drive(1'b0, 16'h0000, 1'b1, 1'b0);
    chk("R7 read clears low", {15'b0, alarm_o}, 16'h0000);
    conv(16'hFF80, 16'hFF80, 1'b0, "R7 low again ignored");
    conv(16'h1910, 16'h1910, 1'b1, "R7 alternates to high");
    conv_read(16'h1910, 16'h1910, 1'b0, "R8 read with standing event");
    conv_read(16'hFF80, 16'hFF80, 1'b1, "R8 event beats read");

    // shutdown
    drive(1'b0, 16'h0000, 1'b0, 1'b1);
    chk("R9 shutdown clears", {15'b0, alarm_o}, 16'h0000);
    conv(16'hFF80, 16'hFF80, 1'b0, "R9 watch high after shutdown");
    conv(16'h1910, 16'h1910, 1'b1, "R9 high event after shutdown");
    drive(1'b1, 16'hC900, 1'b0, 1'b1);
    chk("R9 conversion ignored temp", temp_o, 16'h1910);
    chk("R9 shutdown clears again", {15'b0, alarm_o}, 16'h0000);

    // interrupt, count 6
    load(16'h1900, 16'h0000, 2'd3, 2'd3, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) conv(16'h1910, 16'h1910, 1'b0, "R5 count six pending");
    conv(16'h1910, 16'h1910, 1'b1, "R5 R6 sixth fires");

    // mode change and polarity
    load(16'h1900, 16'h0000, 2'd3, 2'd3, 1'b0, 1'b1);
    chk("R11 mode change clears", {15'b0, alarm_o}, 16'h0000);
    load(16'h1900, 16'h0000, 2'd3, 2'd3, 1'b0, 1'b0);
    chk("R10 active-low idle", {15'b0, alarm_o}, 16'h0001);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule